// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is one bank of 32 general-purpose pins behind a small register bus. Each pin has an output latch and a direction bit. Both can be written whole, or changed bit by bit through write-one-to-set and write-one-to-clear aliases, so software never has to read, modify and write them. When a pin is an input, a per-pin pull enable applies a pull resistor, and the output latch chooses whether it pulls up or down. A per-pin alternate-function bit gives the pad's output and output enable to an outside peripheral.

Pin levels pass through a two-flop synchronizer before they are used. Rising and falling edges of the synchronized level are compared against two independent masks. A qualifying edge latches a pending bit, and writing ones to a clear register removes pending bits. One interrupt line is high while any pending bit is set. Software reads the pending register, services the lowest pin, clears that bit and repeats until the register reads zero.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset the output latch, direction, alternate-function, both mask and pending registers read 0, the pull-disable register reads all ones, `pad_oe` is 0 and `irq` is 0.
- R2: A write to output latch (0x00), pull-disable (0x0C), direction (0x10), alternate select (0x20), rising mask (0x40) or falling mask (0x44) replaces the whole register, and a later read of that offset returns it (0x00 as defined in R8).
- R3: A write to the set aliases (0x04 for the latch, 0x14 for direction) sets only the bits written as 1. All other bits keep their value.
- R4: A write to the clear aliases (0x08 for the latch, 0x18 for direction) clears only the bits written as 1. All other bits keep their value.
- R5: For a pin whose alternate bit is 0, `pad_oe` equals its direction bit (1 = output), and `pad_out` equals its latch bit.
- R6: `pad_pull_en` is 1 exactly when the pad's effective output enable is 0 and its pull-disable bit is 0. `pad_pull_up` is 1 when `pad_pull_en` is 1 and the latch bit is 1 (0 means pull-down).
- R7: For a pin whose alternate bit is 1, `pad_out` follows `alt_out` and `pad_oe` follows `alt_oe`.
- R8: Reading 0x00 returns the latch bit for output pins and the synchronized pin level for input pins.
- R9: A rising edge sets pending bit n (read at 0x48) when rising mask bit n is 1. A falling edge sets it when falling mask bit n is 1. An edge whose mask bit is 0 sets nothing. With both masks set, either edge sets the bit.
- R10: Writing 1 to bit n of 0x4C clears pending bit n, and all ones clears every bit. A new qualifying edge in the same cycle as the clear leaves the bit set.
- R11: `irq` is 1 exactly when at least one pending bit is 1.
- R12: Unmapped offsets (for example 0x30) read as 0 and ignore writes. The set/clear aliases and 0x4C read as 0. Writes to 0x48 have no effect.
- R13: Read data appears on `bus_rdata` in the cycle after the read request and is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pad input levels |
| alt_out | input | 32 | Peripheral output values |
| alt_oe | input | 32 | Peripheral output enables |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pull_en | output | 32 | Pull resistor enable |
| pad_pull_up | output | 32 | Pull polarity, 1 = up |
| irq | output | 1 | OR of the pending bits |

## Verification
On every cycle the assertions check the following: the set and clear aliases touch only the written bits, a pending bit never appears without an enabled mask, a pending bit never drops without a matching clear, pull and drive are never on together, `irq` tracks the pending register, and idle read data is zero. The bench scenarios are needed to show the rest. These are the synchronizer delay before an edge is seen, the either-edge behaviour with both masks set, the rule that a set wins over a clear in the same cycle, the data read mix of latch and pin level, and the alternate-function handover of the pads.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the GPIO bank: register byte offsets.
// Assumes an 8-bit byte address; offsets are word aligned.
package gpio_bank_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA  = 8'h00,
        OFS_DSET  = 8'h04,
        OFS_DCLR  = 8'h08,
        OFS_PDIS  = 8'h0C,
        OFS_DIR   = 8'h10,
        OFS_DIRS  = 8'h14,
        OFS_DIRC  = 8'h18,
        OFS_ALT   = 8'h20,
        OFS_RMSK  = 8'h40,
        OFS_FMSK  = 8'h44,
        OFS_STAT  = 8'h48,
        OFS_ICLR  = 8'h4C
    } reg_ofs_e;

endpackage

// File: rtl/gpio_sync_edge.sv
// Two-flop synchronizer plus edge detector for all pins.
// Assumes pin_in is asynchronous; edges are reported for one cycle
// on the synchronized level compared to its previous sample.
module gpio_sync_edge #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] lvl,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);
    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] prev_q;

    // Synchronize the pad level and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge pulses from the current and previous synchronized samples.
    always_comb begin
        lvl  = sync_q;
        rise = sync_q & ~prev_q;
        fall = ~sync_q & prev_q;
    end
endmodule

// File: rtl/gpio_irq_latch.sv
// Pending-interrupt latch: masked edges set bits, write-one clears them.
// Assumes rise/fall are single-cycle pulses; set has priority over clear.
module gpio_irq_latch #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] rise,
    input  logic [NPINS-1:0] fall,
    input  logic [NPINS-1:0] rmask,
    input  logic [NPINS-1:0] fmask,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] pend,
    output logic             irq
);
    logic [NPINS-1:0] hit;

    // Edges qualified by their own masks.
    always_comb hit = (rise & rmask) | (fall & fmask);

    // Keep pending bits; a clear loses against a new hit.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | hit;
    end

    // Single interrupt line.
    always_comb irq = |pend;
endmodule

// File: rtl/gpio_pad_mux.sv
// Per-pin pad drive: chooses latch or peripheral, and derives pull controls.
// Assumes the pull acts only while the pad is not driven.
module gpio_pad_mux #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] data,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] pdis,
    input  logic [NPINS-1:0] alt,
    input  logic [NPINS-1:0] alt_out,
    input  logic [NPINS-1:0] alt_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pull_en,
    output logic [NPINS-1:0] pad_pull_up
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // Drive source and pull selection for pin i.
        always_comb begin
            pad_out[i]     = alt[i] ? alt_out[i] : data[i];
            pad_oe[i]      = alt[i] ? alt_oe[i]  : dir[i];
            pad_pull_en[i] = ~pad_oe[i] & ~pdis[i];
            pad_pull_up[i] = pad_pull_en[i] & data[i];
        end
    end
endmodule

// File: rtl/gpio_regfile.sv
// Register file and bus decode for the GPIO bank.
// Assumes a single-cycle request; read data is registered and is zero
// in cycles that follow no read.
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  lvl,
    input  logic [NPINS-1:0]  pend,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  pdis_q,
    output logic [NPINS-1:0]  alt_q,
    output logic [NPINS-1:0]  rmask_q,
    output logic [NPINS-1:0]  fmask_q,
    output logic [NPINS-1:0]  clr
);
    logic             wr;
    logic             rd;
    logic [NPINS-1:0] rmux;

    // Request qualifiers.
    always_comb begin
        wr = bus_valid & bus_write;
        rd = bus_valid & ~bus_write;
    end

    // Output latch with whole, set and clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else if (wr) begin
            case (bus_addr)
                OFS_DATA: data_q <= bus_wdata;
                OFS_DSET: data_q <= data_q | bus_wdata;
                OFS_DCLR: data_q <= data_q & ~bus_wdata;
                default:  data_q <= data_q;
            endcase
        end
    end

    // Direction with whole, set and clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= '0;
        else if (wr) begin
            case (bus_addr)
                OFS_DIR:  dir_q <= bus_wdata;
                OFS_DIRS: dir_q <= dir_q | bus_wdata;
                OFS_DIRC: dir_q <= dir_q & ~bus_wdata;
                default:  dir_q <= dir_q;
            endcase
        end
    end

    // Plain configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdis_q  <= '1;
            alt_q   <= '0;
            rmask_q <= '0;
            fmask_q <= '0;
        end else if (wr) begin
            if (bus_addr == OFS_PDIS) pdis_q  <= bus_wdata;
            if (bus_addr == OFS_ALT)  alt_q   <= bus_wdata;
            if (bus_addr == OFS_RMSK) rmask_q <= bus_wdata;
            if (bus_addr == OFS_FMSK) fmask_q <= bus_wdata;
        end
    end

    // Write-one-to-clear vector for the pending latch.
    always_comb clr = (wr && bus_addr == OFS_ICLR) ? bus_wdata : '0;

    // Read selection; aliases and unmapped offsets return zero.
    always_comb begin
        case (bus_addr)
            OFS_DATA: rmux = (dir_q & data_q) | (~dir_q & lvl);
            OFS_PDIS: rmux = pdis_q;
            OFS_DIR:  rmux = dir_q;
            OFS_ALT:  rmux = alt_q;
            OFS_RMSK: rmux = rmask_q;
            OFS_FMSK: rmux = fmask_q;
            OFS_STAT: rmux = pend;
            default:  rmux = '0;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd ? rmux : '0;
    end
endmodule

// File: rtl/gpio_edge_bank.sv
// Top of one GPIO bank: register file, synchronizer, pending latch and pad mux.
// Assumes a single clock domain for the bus; pins are asynchronous.
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pull_en,
    output logic [NPINS-1:0]  pad_pull_up,
    output logic              irq
);
    logic [NPINS-1:0] lvl, rise, fall, pend, clr;
    logic [NPINS-1:0] data_q, dir_q, pdis_q, alt_q, rmask_q, fmask_q;

    gpio_sync_edge #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    gpio_regfile #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lvl(lvl), .pend(pend),
        .data_q(data_q), .dir_q(dir_q), .pdis_q(pdis_q), .alt_q(alt_q),
        .rmask_q(rmask_q), .fmask_q(fmask_q), .clr(clr)
    );

    gpio_irq_latch #(.NPINS(NPINS)) u_irq (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .rmask(rmask_q), .fmask(fmask_q), .clr(clr),
        .pend(pend), .irq(irq)
    );

    gpio_pad_mux #(.NPINS(NPINS)) u_pad (
        .data(data_q), .dir(dir_q), .pdis(pdis_q), .alt(alt_q),
        .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
    );
endmodule

// File: rtl/gpio_edge_bank_chk.sv
// Property checker for the GPIO bank, bound into every instance.
// Assumes it sees the top's ports plus the latch, mask and pending state.
module gpio_edge_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_pull_en,
    input logic              irq,
    input logic [NPINS-1:0]  data_q,
    input logic [NPINS-1:0]  rmask_q,
    input logic [NPINS-1:0]  fmask_q,
    input logic [NPINS-1:0]  pend
);
    logic [NPINS-1:0] clr_v;
    logic             rd_req;

    // Clear vector and read request seen at the bus.
    always_comb begin
        clr_v  = (bus_valid && bus_write && bus_addr == OFS_ICLR) ? bus_wdata : '0;
        rd_req = bus_valid && !bus_write;
    end

    a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFS_DSET)
        |=> data_q == ($past(data_q) | $past(bus_wdata)));

    a_r4_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == OFS_DCLR)
        |=> data_q == ($past(data_q) & ~$past(bus_wdata)));

    a_r6_no_pull_while_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == '0);

    a_r9_no_unmasked_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & ~($past(rmask_q) | $past(fmask_q))) == '0);

    a_r10_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) & ~$past(clr_v) & ~pend) == '0);

    a_r11_irq_tracks_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pend != '0));

    a_r13_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> bus_rdata == '0);
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .irq(irq),
    .data_q(data_q), .rmask_q(rmask_q), .fmask_q(fmask_q), .pend(pend)
);

// File: tb/tb_gpio_edge_bank.sv
`timescale 1ns/100ps
module tb_gpio_edge_bank;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] alt_out = '0;
    logic [N-1:0] alt_oe = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;
    logic         irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of the register state
    logic [N-1:0] m_data, m_dir, m_pdis, m_alt, m_rm, m_fm;

    always #2.5 clk = ~clk;

    gpio_edge_bank #(.NPINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .irq(irq)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [N-1:0] eff_oe();
        return (m_alt & alt_oe) | (~m_alt & m_dir);
    endfunction

    function automatic logic [N-1:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return (m_dir & m_data) | (~m_dir & pin_in);
            8'h0C: return m_pdis;
            8'h10: return m_dir;
            8'h20: return m_alt;
            8'h40: return m_rm;
            8'h44: return m_fm;
            default: return '0;
        endcase
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic [N-1:0] d);
        case (a)
            8'h00: m_data = d;
            8'h04: m_data = m_data | d;
            8'h08: m_data = m_data & ~d;
            8'h0C: m_pdis = d;
            8'h10: m_dir = d;
            8'h14: m_dir = m_dir | d;
            8'h18: m_dir = m_dir & ~d;
            8'h20: m_alt = d;
            8'h40: m_rm = d;
            8'h44: m_fm = d;
            default: ;
        endcase
    endfunction

    task automatic check_pads(input string tag);
        logic [N-1:0] oe;
        oe = eff_oe();
        check({tag, " R5/R7 pad_oe"}, pad_oe, oe);
        check({tag, " R5/R7 pad_out"}, pad_out, (m_alt & alt_out) | (~m_alt & m_data));
        check({tag, " R6 pull_en"}, pad_pull_en, ~oe & ~m_pdis);
        check({tag, " R6 pull_up"}, pad_pull_up, ~oe & ~m_pdis & m_data);
    endtask

    task automatic wait_sync();
        repeat (4) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] rv;
        logic [7:0] wlist [10];
        logic [7:0] rlist [12];
        void'($urandom(32'h5EED_0042));
        wlist = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h40, 8'h44};
        rlist = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h40, 8'h44, 8'h30, 8'h4C};
        m_data = '0; m_dir = '0; m_pdis = '1; m_alt = '0; m_rm = '0; m_fm = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 irq", {31'd0, irq}, '0);
        bus_rd(8'h00, rv); check("R1 data", rv, '0);
        bus_rd(8'h0C, rv); check("R1 pdis", rv, '1);
        bus_rd(8'h10, rv); check("R1 dir", rv, '0);
        bus_rd(8'h20, rv); check("R1 alt", rv, '0);
        bus_rd(8'h40, rv); check("R1 rmask", rv, '0);
        bus_rd(8'h44, rv); check("R1 fmask", rv, '0);
        bus_rd(8'h48, rv); check("R1 status", rv, '0);

        // R3/R4 directed alias corners
        bus_wr(8'h00, 32'hF0F0_F0F0); model_wr(8'h00, 32'hF0F0_F0F0);
        bus_wr(8'h10, 32'hFFFF_FFFF); model_wr(8'h10, 32'hFFFF_FFFF);
        bus_wr(8'h04, 32'h0000_000F); model_wr(8'h04, 32'h0000_000F);
        bus_rd(8'h00, rv); check("R3 data set alias", rv, 32'hF0F0_F0FF);
        bus_wr(8'h08, 32'hF000_0001); model_wr(8'h08, 32'hF000_0001);
        bus_rd(8'h00, rv); check("R4 data clear alias", rv, 32'h00F0_F0FE);
        bus_wr(8'h18, 32'h0000_FFFF); model_wr(8'h18, 32'h0000_FFFF);
        bus_rd(8'h10, rv); check("R4 dir clear alias", rv, 32'hFFFF_0000);
        bus_wr(8'h14, 32'h0000_0100); model_wr(8'h14, 32'h0000_0100);
        bus_rd(8'h10, rv); check("R3 dir set alias", rv, 32'hFFFF_0100);

        // R8 mixed data read with pins held
        pin_in = 32'h1234_5678;
        wait_sync();
        bus_rd(8'h00, rv); check("R8 data read mix", rv, exp_read(8'h00));

        // R12 unmapped offset and read-only status
        bus_wr(8'h30, 32'hFFFF_FFFF);
        bus_rd(8'h30, rv); check("R12 unmapped reads zero", rv, '0);
        bus_wr(8'h48, 32'hFFFF_FFFF);
        bus_rd(8'h48, rv); check("R12 status write ignored", rv, '0);
        check("R12 unmapped write leaves pads", pad_oe, eff_oe());

        // R13 one-cycle latency, zero when idle
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h10;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R13 rdata after one cycle", bus_rdata, m_dir);
        @(negedge clk);
        check("R13 rdata idle zero", bus_rdata, '0);

        // Random phase: R2, R3, R4, R5, R6, R7, R8, R12
        pin_in = $urandom; alt_out = $urandom; alt_oe = $urandom;
        wait_sync();
        for (int i = 0; i < 300; i++) begin
            logic [7:0] wa, ra;
            logic [N-1:0] wd;
            wa = wlist[$urandom % 10];
            wd = $urandom;
            bus_wr(wa, wd); model_wr(wa, wd);
            ra = rlist[$urandom % 12];
            bus_rd(ra, rv);
            check("R2/R8/R12 random read", rv, exp_read(ra));
            check_pads("random");
        end

        // Edge interrupts: R9, R10, R11
        bus_wr(8'h40, '0); model_wr(8'h40, '0);
        bus_wr(8'h44, '0); model_wr(8'h44, '0);
        pin_in = '0;
        wait_sync();
        bus_wr(8'h4C, '1);
        bus_wr(8'h40, 32'h0000_0008); model_wr(8'h40, 32'h0000_0008);
        bus_wr(8'h44, 32'h0000_0028); model_wr(8'h44, 32'h0000_0028);
        @(negedge clk); pin_in = 32'h0000_0028;          // rise on 3 and 5
        wait_sync();
        bus_rd(8'h48, rv); check("R9 rising masked vs unmasked", rv, 32'h0000_0008);
        check("R11 irq high", {31'd0, irq}, 32'd1);
        bus_wr(8'h4C, 32'h0000_0008);
        bus_rd(8'h48, rv); check("R10 single clear", rv, '0);
        check("R11 irq low", {31'd0, irq}, 32'd0);
        @(negedge clk); pin_in = 32'h0000_0000;          // fall on 3 and 5
        wait_sync();
        bus_rd(8'h48, rv); check("R9 falling both masks", rv, 32'h0000_0028);
        bus_wr(8'h4C, '1);
        bus_rd(8'h48, rv); check("R10 clear all", rv, '0);

        // R10 set wins over clear in the same cycle
        @(negedge clk); pin_in = 32'h0000_0008;          // rise on 3
        wait_sync();
        @(negedge clk); pin_in = 32'h0000_0000;          // fall on 3
        @(negedge clk);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h4C; bus_wdata = 32'h0000_0008;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        bus_rd(8'h48, rv); check("R10 set beats clear", rv, 32'h0000_0008);
        check("R11 irq stays", {31'd0, irq}, 32'd1);
        bus_wr(8'h4C, '1);

        // R9 unmasked pin 0 edges leave status clear
        @(negedge clk); pin_in = 32'h0000_0001;
        wait_sync();
        @(negedge clk); pin_in = 32'h0000_0000;
        wait_sync();
        bus_rd(8'h48, rv); check("R9 unmasked edges ignored", rv, '0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule